// File: doc/BRIEF.md
# Parity-Checked Serial Character Receiver

This block takes an asynchronous serial line and turns each incoming character into a parallel byte in the system clock domain. A character is framed as a low start bit, eight data bits sent least significant bit first, one parity bit and a high stop bit. The line is brought into the clock domain through two flip-flops. A falling edge on the synchronized line marks a possible start bit. The receiver looks at the line again half a bit period later, so a short low glitch does not start a frame. After that, each bit is sampled in the middle of its period.

When the stop bit has been sampled, the byte is presented on the data output and a valid strobe goes high for one clock. If the data bits and the parity bit together hold an odd number of ones, the parity error strobe is raised in that same clock. The stop bit value only marks the end of the frame: the receiver goes back to waiting for a start edge whether the stop bit reads high or low. The bit period is the clock frequency divided by the baud rate, and the default baud rate is 115200.

Top module: `parity_uart_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rxValid and parityErr are 0 and rxData is 0.
- R2: The first data bit after the start bit lands in rxData[0] and the eighth lands in rxData[7]. The byte is shown on rxData in the cycle in which rxValid is high.
- R3: With P = CLK_FREQ_HZ/BAUD_RATE clocks per bit, a frame whose start bit is applied just before rising edge number 1 makes rxValid high for exactly one cycle, beginning at rising edge number 3 + P/2 + 10*P. Two valid strobes are always at least 10*P cycles apart.
- R4: Parity is even. parityErr is 1 together with rxValid when the eight data bits plus the parity bit hold an odd number of ones, and 0 otherwise.
- R5: parityErr is high for only one cycle at a time and never without rxValid.
- R6: A low pulse on the line shorter than P/2 cycles, followed by a high line, produces no rxValid.
- R7: A frame whose stop bit reads 0 is still reported with rxValid. A following frame, started after the line has gone high again, is received correctly.
- R8: Frames sent back to back, where each start bit directly follows the previous stop bit, are each received with their own rxValid strobe and the correct data.
- R9: rxData keeps its value in every cycle in which rxValid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxSerial | input | 1 | Asynchronous serial input, high when idle |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe marking a received frame |
| parityErr | output | 1 | One-cycle strobe marking a parity mismatch in that frame |

## Verification
Some properties hold in every cycle and are checked by the bound assertions. These are: the valid strobe lasts one cycle, the error strobe never appears without it, the data holds between strobes, and strobes are spaced at least ten bit periods apart. Other behaviour depends on what is sent on the line, so only the bench scenarios can show it. This covers the exact strobe cycle after a start edge, the bit order and the even-parity decision. It also covers rejecting a short low glitch, accepting a frame whose stop bit is low, and receiving frames back to back. The bench compares these against a reference model on every clock.

// File: rtl/parity_uart_rx_pkg.sv
package parity_uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // Strobes from the sequencer to the datapath; each is one cycle wide.
  typedef struct packed {
    logic clearBits;    // new frame begins: clear parity accumulator
    logic shiftIn;      // sample a data bit into the shift register
    logic checkParity;  // sample the parity bit into the accumulator
    logic frameDone;    // stop bit reached: publish byte and strobes
  } rxStrobes_t;

endpackage

// File: rtl/parity_uart_rx_datapath.sv
module parity_uart_rx_datapath
  import parity_uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxSerial,
  input  rxStrobes_t           strobes,
  output logic                 lineLow,
  output logic                 fallSeen,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxValid,
  output logic                 parityErr
);

  logic syncMeta;
  logic syncLine;
  logic linePrev;
  logic [DATA_BITS-1:0] shiftReg;
  logic parityAcc;

  // Two-flop synchronizer, then one more flop for edge detection.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncMeta <= 1'b1;
      syncLine <= 1'b1;
      linePrev <= 1'b1;
    end else begin
      syncMeta <= rxSerial;
      syncLine <= syncMeta;
      linePrev <= syncLine;
    end
  end

  assign lineLow  = ~syncLine;
  assign fallSeen = linePrev & ~syncLine;

  // Least significant bit arrives first: shift in from the top.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityAcc <= 1'b0;
    end else begin
      if (strobes.clearBits) begin
        parityAcc <= 1'b0;
      end else if (strobes.shiftIn || strobes.checkParity) begin
        parityAcc <= parityAcc ^ syncLine;
      end
      if (strobes.shiftIn) begin
        shiftReg <= {syncLine, shiftReg[DATA_BITS-1:1]};
      end
    end
  end

  // Even parity: a set accumulator after the parity bit means a mismatch.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
    end else begin
      rxValid   <= strobes.frameDone;
      parityErr <= strobes.frameDone & parityAcc;
      if (strobes.frameDone) begin
        rxData <= shiftReg;
      end
    end
  end

endmodule

// File: rtl/parity_uart_rx_ctrl.sv
module parity_uart_rx_ctrl
  import parity_uart_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1736,
  parameter int DATA_BITS    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineLow,
  input  logic       fallSeen,
  output rxStrobes_t strobes
);

  localparam int HALF_BIT = CLKS_PER_BIT / 2;
  localparam int CNT_W    = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W    = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_BIT - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] clkCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             bitEnd;
  logic             halfEnd;

  assign bitEnd  = (clkCnt == BIT_LAST);
  assign halfEnd = (clkCnt == HALF_LAST);

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE:  strobes.clearBits   = fallSeen;
      ST_DATA:  strobes.shiftIn     = bitEnd;
      ST_PAR:   strobes.checkParity = bitEnd;
      ST_STOP:  strobes.frameDone   = bitEnd;
      default:  strobes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      clkCnt <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          clkCnt <= '0;
          bitCnt <= '0;
          if (fallSeen) state <= ST_START;
        end
        ST_START: begin
          if (halfEnd) begin
            clkCnt <= '0;
            state  <= lineLow ? ST_DATA : ST_IDLE;
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            clkCnt <= '0;
            if (bitCnt == DATA_LAST) begin
              state <= ST_PAR;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bitEnd) begin
            clkCnt <= '0;
            state  <= ST_STOP;
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitEnd) begin
            clkCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            clkCnt <= clkCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/parity_uart_rx.sv
module parity_uart_rx
  import parity_uart_rx_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int BAUD_RATE   = 115_200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSerial,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       parityErr
);

  localparam int CLKS_PER_BIT = CLK_FREQ_HZ / BAUD_RATE;
  localparam int DATA_BITS    = 8;

  rxStrobes_t strobes;
  logic       lineLow;
  logic       fallSeen;

  parity_uart_rx_ctrl #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_BITS   (DATA_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lineLow (lineLow),
    .fallSeen(fallSeen),
    .strobes (strobes)
  );

  parity_uart_rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxSerial (rxSerial),
    .strobes  (strobes),
    .lineLow  (lineLow),
    .fallSeen (fallSeen),
    .rxData   (rxData),
    .rxValid  (rxValid),
    .parityErr(parityErr)
  );

endmodule

// File: rtl/parity_uart_rx_checker.sv
module parity_uart_rx_checker #(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int BAUD_RATE   = 115_200
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       parityErr
);

  localparam int CLKS_PER_BIT = CLK_FREQ_HZ / BAUD_RATE;
  localparam int MIN_GAP      = 10 * CLKS_PER_BIT;

  int gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= 0;
    end else if (rxValid) begin
      gapCnt <= 1;
    end else if (gapCnt < MIN_GAP) begin
      gapCnt <= gapCnt + 1;
    end
  end

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_valid_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && gapCnt != 0) |-> gapCnt >= MIN_GAP);

  assert_err_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> rxValid);

  assert_err_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> !parityErr);

  assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

endmodule

bind parity_uart_rx parity_uart_rx_checker #(
  .CLK_FREQ_HZ(CLK_FREQ_HZ),
  .BAUD_RATE  (BAUD_RATE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxData   (rxData),
  .rxValid  (rxValid),
  .parityErr(parityErr)
);

// File: tb/parity_uart_rx_tb.sv
`timescale 1ns/1ps
module parity_uart_rx_tb;

  localparam int CLK_HZ = 1_600_000;
  localparam int BAUD   = 100_000;
  localparam int P      = CLK_HZ / BAUD;        // 16 clocks per bit
  localparam int LAT    = 3 + P / 2 + 10 * P;   // R3 latency in rising edges

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxSerial = 1'b1;
  logic [7:0] rxData;
  logic       rxValid;
  logic       parityErr;

  parity_uart_rx #(.CLK_FREQ_HZ(CLK_HZ), .BAUD_RATE(BAUD)) u_dut (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int         due;
    logic [7:0] data;
    logic       perr;
    string      req;
  } expEvent_t;

  expEvent_t expQ[$];
  int        cyc = 0;
  int        checks = 0;
  int        errors = 0;
  bit        monOn = 0;
  bit        done = 0;
  string     quietReq = "R3";
  logic [7:0] heldData = 8'h00;
  int        validSeen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Reference model: compare against the expected event queue on every clock.
  always @(negedge clk) begin
    if (monOn) begin
      bit expV;
      expV = (expQ.size() > 0) && (expQ[0].due == cyc);
      if (rxValid) validSeen++;
      if (expV) begin
        check(rxValid === 1'b1, expQ[0].req, "rxValid strobe", rxValid, 1);
        check(rxData === expQ[0].data, expQ[0].req, "rxData", rxData, expQ[0].data);
        check(parityErr === expQ[0].perr, "R4", "parityErr", parityErr, expQ[0].perr);
        heldData = expQ[0].data;
        void'(expQ.pop_front());
      end else begin
        check(rxValid === 1'b0, quietReq, "unexpected rxValid", rxValid, 0);
        check(parityErr === 1'b0, "R5", "parityErr without frame", parityErr, 0);
        check(rxData === heldData, "R9", "rxData hold", rxData, heldData);
      end
    end
  end

  task automatic holdBit(input logic v);
    rxSerial = v;
    repeat (P) @(negedge clk);
  endtask

  // Caller is at a negedge; the start bit is applied here.
  task automatic sendFrame(input logic [7:0] d, input bit flipPar,
                           input logic stopVal, input string req);
    expEvent_t e;
    e.due  = cyc + LAT;
    e.data = d;
    e.perr = flipPar;
    e.req  = req;
    expQ.push_back(e);
    holdBit(1'b0);
    for (int i = 0; i < 8; i++) holdBit(d[i]);
    holdBit((^d) ^ flipPar);   // R4: even parity bit
    holdBit(stopVal);
    rxSerial = 1'b1;
  endtask

  task automatic idle(input int n);
    rxSerial = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rxValid === 1'b0, "R1", "rxValid in reset", rxValid, 0);
    check(parityErr === 1'b0, "R1", "parityErr in reset", parityErr, 0);
    check(rxData === 8'h00, "R1", "rxData in reset", rxData, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rxValid === 1'b0 && parityErr === 1'b0 && rxData === 8'h00,
          "R1", "outputs after reset", {rxValid, parityErr, rxData}, 0);
    monOn = 1;
    idle(4);

    // R2/R3: basic frames, bit order
    sendFrame(8'hA5, 0, 1'b1, "R2");
    idle(2 * P);
    sendFrame(8'h01, 0, 1'b1, "R2");
    idle(2 * P);
    sendFrame(8'h80, 0, 1'b1, "R3");
    idle(2 * P);

    // R4/R5: wrong parity bit
    sendFrame(8'h5A, 1, 1'b1, "R4");
    idle(2 * P);
    sendFrame(8'h07, 1, 1'b1, "R5");
    idle(2 * P);

    // R6: short low glitch must not start a frame
    quietReq = "R6";
    validSeen = 0;
    rxSerial = 1'b0;
    repeat (P / 2 - 3) @(negedge clk);
    idle(13 * P);
    check(validSeen == 0, "R6", "strobes after glitch", validSeen, 0);
    quietReq = "R3";

    // R7: stop bit low, then a normal frame
    sendFrame(8'h3C, 0, 1'b0, "R7");
    idle(P);
    sendFrame(8'hC3, 0, 1'b1, "R7");
    idle(2 * P);

    // R8: back-to-back frames
    sendFrame(8'h00, 0, 1'b1, "R8");
    sendFrame(8'hFF, 0, 1'b1, "R8");
    sendFrame(8'h69, 1, 1'b1, "R8");
    idle(3 * P);

    check(expQ.size() == 0, "R3", "frames left unreported", expQ.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule